// File: doc/BRIEF.md
# Key-Activated Watchdog Timer

This block is a watchdog built on a 64-bit up-counter. The counter is kept as two 32-bit halves, and it is compared with a 64-bit period value. Software reaches the block through a small register bus with a write strobe, an address, write data and combinational read data. Through this bus it loads the period, sets a mode-enable bit and writes 16-bit key values.

Setting the enable bit arms the block. An ordered pair of key writes then makes it active, and the same pair later services it by restarting the count. When the count reaches the period in the active state, the block raises a one-cycle interrupt pulse and an eight-cycle device-reset pulse, and it sets a timeout flag. An external reset circuit can take either signal.

A period match while the block is only armed still sets the flag. It produces no interrupt and no reset. The flag is cleared when the block enters the active state, and software can also clear it by writing 1 to it.

Top module: `keyed_watchdog`

## Requirements
- R1: In the idle state the count stays at zero. Once enabled, the count rises by one each clock as a 64-bit value held in two halves: the low half reads at address 4 and the high half at address 5.
- R2: When the full 64-bit count equals the 64-bit period, the count is zero on the next clock. A match in the low half alone, with the high halves different, does not wrap the count.
- R3: The control register is at address 0. Bit 0 is the mode enable, bit 1 the timeout flag, and bits 3:2 the state code (0 idle, 1 armed, 2 first key seen, 3 active). Key writes go to address 1, bits 15:0, and they are ignored in the idle state. The period low half is at address 2 and the high half at address 3; both reset to all ones.
- R4: Writing enable=1 in idle moves the block to armed. In armed, key 16'hA5C6 moves it to first-key-seen and any other key leaves it armed. In first-key-seen, key 16'hDA7E moves it to active and any other key returns it to armed.
- R5: Entering the active state clears the timeout flag and restarts the count from zero.
- R6: A period match in the armed or first-key-seen state sets the timeout flag but produces no interrupt and no reset pulse.
- R7: A period match in the active state sets the flag. On the following clock it raises `wd_irq` for one cycle and `wd_reset` for 8 cycles, both starting together.
- R8: In the active state, key 16'hA5C6 followed by 16'hDA7E restarts the count at zero without a timeout. Repeating 16'hA5C6 before 16'hDA7E is allowed.
- R9: In the active state, any key other than 16'hA5C6, or 16'hDA7E without a preceding 16'hA5C6, forces a timeout on the next clock: flag set, interrupt and reset pulse raised, count zero.
- R10: The active state is left only through `rst_n`, and writes clearing the enable bit are then ignored. Clearing the enable bit in armed or first-key-seen returns the block to idle.
- R11: Writing 1 to the flag bit clears it. A timeout in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_irq | output | 1 | One-cycle timeout interrupt pulse |
| wd_reset | output | 1 | Eight-cycle device-reset pulse |

## Verification
The bench sets a flag through a match while the block is only armed. This catches a design that resets the device before activation, and it shows whether activation clears the flag. It walks wrong-key, repeated-first-key and second-key-first patterns through the key states, because a loose key check would activate on the wrong order. It checks that clearing the enable bit cannot stop an active watchdog. It also checks that a lone or unknown key forces a timeout instead of being dropped. Pulse widths and the cycle of the natural timeout are measured, so an off-by-one in the compare or the stretcher shows up as a wrong count. A period whose low half matches while its high half does not is used to expose a compare that only looks at the low 32 bits.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ARMED  = 2'd1,
        ST_KEY1   = 2'd2,
        ST_ACTIVE = 2'd3
    } wdk_state_e;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_KEY      = 1;
    localparam int ADDR_PRD_BASE = 2;
endpackage

// File: rtl/wdk_counter.sv
module wdk_counter #(
    parameter int HALF_W     = 32,
    parameter int NUM_HALVES = 2,
    localparam int CW        = HALF_W * NUM_HALVES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          clear,
    input  logic [CW-1:0] period,
    output logic [CW-1:0] count,
    output logic          match
);
    logic [NUM_HALVES-1:0][HALF_W-1:0] cnt_d, cnt_q;

    assign match = run && (cnt_q == period);

    always_comb begin
        logic carry;
        carry = 1'b1;
        cnt_d = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (run) begin
            if (match) begin
                cnt_d = '0;
            end else begin
                for (int i = 0; i < NUM_HALVES; i++) begin
                    cnt_d[i] = cnt_q[i] + HALF_W'(carry);
                    carry    = carry & (&cnt_q[i]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_out
        assign count[g*HALF_W +: HALF_W] = cnt_q[g];
    end
endmodule

// File: rtl/wdk_keyfsm.sv
module wdk_keyfsm
    import wdk_pkg::*;
#(
    parameter int              KEY_W      = 16,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 16'hA5C6,
    parameter logic [KEY_W-1:0] KEY_SECOND = 16'hDA7E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_wr,
    input  logic             en_val,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_val,
    output wdk_state_e       state,
    output logic             enter_active,
    output logic             svc_reload,
    output logic             force_to
);
    typedef struct packed {
        wdk_state_e st;
        logic       pend;
    } fsm_t;

    fsm_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        enter_active = 1'b0;
        svc_reload   = 1'b0;
        force_to     = 1'b0;
        if (en_wr) begin
            unique case (s_q.st)
                ST_IDLE:          if (en_val) s_d.st = ST_ARMED;
                ST_ARMED, ST_KEY1: if (!en_val) s_d.st = ST_IDLE;
                default: ;
            endcase
        end
        if (key_wr) begin
            unique case (s_q.st)
                ST_ARMED: if (key_val == KEY_FIRST) s_d.st = ST_KEY1;
                ST_KEY1: begin
                    if (key_val == KEY_SECOND) begin
                        s_d.st       = ST_ACTIVE;
                        s_d.pend     = 1'b0;
                        enter_active = 1'b1;
                    end else begin
                        s_d.st = ST_ARMED;
                    end
                end
                ST_ACTIVE: begin
                    if (key_val == KEY_FIRST) begin
                        s_d.pend = 1'b1;
                    end else if (key_val == KEY_SECOND && s_q.pend) begin
                        s_d.pend   = 1'b0;
                        svc_reload = 1'b1;
                    end else begin
                        s_d.pend = 1'b0;
                        force_to = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, pend: 1'b0};
        else        s_q <= s_d;
    end

    assign state = s_q.st;
endmodule

// File: rtl/wdk_pulse.sv
module wdk_pulse #(
    parameter int LEN = 8,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (trig)               cnt_d = CW'(LEN);
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse = (cnt_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdk_pkg::*;
#(
    parameter int HALF_W     = 32,
    parameter int NUM_HALVES = 2,
    parameter int KEY_W      = 16,
    parameter int RST_LEN    = 8,
    parameter int ADDR_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [HALF_W-1:0] bus_wdata,
    output logic [HALF_W-1:0] bus_rdata,
    output logic              wd_irq,
    output logic              wd_reset
);
    localparam int CW            = HALF_W * NUM_HALVES;
    localparam int ADDR_CNT_BASE = ADDR_PRD_BASE + NUM_HALVES;

    typedef struct packed {
        logic [NUM_HALVES-1:0][HALF_W-1:0] prd;
        logic                              flag;
        logic                              irq;
    } regs_t;

    regs_t      r_d, r_q;
    wdk_state_e fsm_state;
    logic       enter_active, svc_reload, force_to;
    logic       cnt_match, cnt_clear, cnt_run, timeout_ev, flag_w;
    logic [CW-1:0] count_w;
    logic       ctrl_wr, key_wr;

    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(ADDR_CTRL));
    assign key_wr  = bus_wr && (bus_addr == ADDR_W'(ADDR_KEY));

    wdk_keyfsm #(.KEY_W(KEY_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_wr        (ctrl_wr),
        .en_val       (bus_wdata[0]),
        .key_wr       (key_wr),
        .key_val      (bus_wdata[KEY_W-1:0]),
        .state        (fsm_state),
        .enter_active (enter_active),
        .svc_reload   (svc_reload),
        .force_to     (force_to)
    );

    assign cnt_run   = (fsm_state != ST_IDLE);
    assign cnt_clear = (fsm_state == ST_IDLE) | enter_active | svc_reload | force_to;

    wdk_counter #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (cnt_run),
        .clear  (cnt_clear),
        .period (r_q.prd),
        .count  (count_w),
        .match  (cnt_match)
    );

    assign timeout_ev = (cnt_match && fsm_state == ST_ACTIVE) || force_to;

    always_comb begin
        r_d     = r_q;
        r_d.irq = timeout_ev;
        for (int i = 0; i < NUM_HALVES; i++) begin
            if (bus_wr && bus_addr == ADDR_W'(ADDR_PRD_BASE + i)) r_d.prd[i] = bus_wdata;
        end
        if (ctrl_wr && bus_wdata[1]) r_d.flag = 1'b0;
        if (cnt_match || force_to)   r_d.flag = 1'b1;
        if (enter_active)            r_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{prd: '1, flag: 1'b0, irq: 1'b0};
        else        r_q <= r_d;
    end

    wdk_pulse #(.LEN(RST_LEN)) u_rst (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (timeout_ev),
        .pulse (wd_reset)
    );

    assign wd_irq = r_q.irq;
    assign flag_w = r_q.flag;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(ADDR_CTRL)) begin
            bus_rdata[0]   = cnt_run;
            bus_rdata[1]   = r_q.flag;
            bus_rdata[3:2] = fsm_state;
        end
        for (int i = 0; i < NUM_HALVES; i++) begin
            if (bus_addr == ADDR_W'(ADDR_PRD_BASE + i)) bus_rdata = r_q.prd[i];
            if (bus_addr == ADDR_W'(ADDR_CNT_BASE + i)) bus_rdata = count_w[i*HALF_W +: HALF_W];
        end
    end
endmodule

// File: rtl/wdk_checker.sv
module wdk_checker
    import wdk_pkg::*;
#(
    parameter int CW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input wdk_state_e    st,
    input logic          flag,
    input logic          irq,
    input logic          rst_pulse,
    input logic          match,
    input logic          cnt_clr,
    input logic [CW-1:0] count
);
    AST_IDLE_HOLDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> (count == '0)); // R1
    AST_MATCH_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (match && !cnt_clr) |=> (count == '0)); // R2
    AST_RESET_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_pulse) |-> (st == ST_ACTIVE)); // R6
    AST_IRQ_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rst_pulse); // R7
    AST_IRQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> flag); // R7
    AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACTIVE) |=> (st == ST_ACTIVE)); // R10
endmodule

bind keyed_watchdog wdk_checker #(.CW(64)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (fsm_state),
    .flag      (flag_w),
    .irq       (wd_irq),
    .rst_pulse (wd_reset),
    .match     (cnt_match),
    .cnt_clr   (cnt_clear),
    .count     (count_w)
);

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wd_irq, wd_reset;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_watchdog dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wd_irq(wd_irq), .wd_reset(wd_reset)
    );

    // key in [17:2], expected state code after the write in [1:0]
    localparam logic [17:0] KEY_VEC [8] = '{
        {16'h1234, 2'd1}, {16'hA5C6, 2'd2}, {16'hA5C6, 2'd1}, {16'hA5C6, 2'd2},
        {16'h0000, 2'd1}, {16'hDA7E, 2'd1}, {16'hA5C6, 2'd2}, {16'hDA7E, 2'd3}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; tests++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, m;
        logic seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        rd(0, v); check("R3 ctrl after reset", v, 32'h0);
        rd(4, v); check("R1 count after reset", v, 32'h0);
        rd(2, v); check("R3 period low reset", v, 32'hFFFF_FFFF);
        check("R7 outputs after reset", {30'd0, wd_irq, wd_reset}, 32'h0);

        // key ignored while idle
        wr(1, 32'hA5C6);
        rd(0, v); check("R3 key ignored in idle", v, 32'h0);

        // high half of period differs: no wrap
        wr(2, 32'd5); wr(3, 32'd1);
        wr(0, 32'h1);
        rd(0, v); check("R4 enable arms", v, 32'h5);
        repeat (20) @(negedge clk);
        rd(4, v); check("R2 high half blocks match", v, 32'd20);
        rd(0, v); check("R2 no flag without full match", v, 32'h5);

        // disarm, then period 5 while armed
        wr(0, 32'h0);
        rd(0, v); check("R10 clearing enable in armed", v, 32'h0);
        wr(3, 32'd0);
        wr(0, 32'h1);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (wd_irq || wd_reset) seen = 1'b1;
        end
        rd(4, v); check("R2 wrap count", v, 32'd2);
        check("R6 no irq/reset while armed", {31'd0, seen}, 32'h0);
        rd(0, v); check("R6 flag set while armed", v, 32'h7);

        // key sequence table
        wr(2, 32'd1000);
        for (int i = 0; i < 8; i++) begin
            wr(1, {16'h0, KEY_VEC[i][17:2]});
            rd(0, v);
            check($sformatf("R4 key vector %0d", i), {30'd0, v[3:2]}, {30'd0, KEY_VEC[i][1:0]});
        end
        rd(4, v); check("R5 count zero on entry", v, 32'h0);
        rd(0, v); check("R5 flag cleared on entry", v, 32'hD);

        wr(0, 32'h0);
        rd(0, v); check("R10 enable clear ignored", v, 32'hD);

        // service
        repeat (300) @(negedge clk);
        wr(1, 32'hA5C6); wr(1, 32'hDA7E);
        rd(4, v); check("R8 service reloads", v, 32'h0);
        check("R8 no timeout on service", {30'd0, wd_irq, wd_reset}, 32'h0);

        // natural timeout in active, period 20
        wr(2, 32'd20);
        wr(1, 32'hA5C6); wr(1, 32'hDA7E);
        n = 0;
        while (!wd_irq && n < 100) begin @(negedge clk); n++; end
        check("R7 timeout cycle", n, 21);
        rd(0, v); check("R7 flag on timeout", v, 32'hF);
        m = 0;
        while (wd_reset && m < 50) begin
            if (m == 1) check("R7 irq one cycle", {31'd0, wd_irq}, 32'h0);
            @(negedge clk); m++;
        end
        check("R7 reset pulse length", m, 8);

        wr(2, 32'd100000);
        wr(0, 32'h3);
        rd(0, v); check("R11 flag write-one-clear", v, 32'hD);

        // forced timeouts
        wr(1, 32'h1111);
        check("R9 wrong key forces timeout", {30'd0, wd_irq, wd_reset}, 32'h3);
        rd(4, v); check("R9 count zero on forced", v, 32'h0);
        rd(0, v); check("R9 flag on forced", v, 32'hF);
        repeat (10) @(negedge clk);
        wr(1, 32'hDA7E);
        check("R9 lone second key forces timeout", {30'd0, wd_irq, wd_reset}, 32'h3);
        repeat (10) @(negedge clk);

        wr(1, 32'hA5C6); wr(1, 32'hA5C6); wr(1, 32'hDA7E);
        check("R8 repeated first key service", {30'd0, wd_irq, wd_reset}, 32'h0);
        rd(4, v); check("R8 repeated first key reload", v, 32'h0);

        // block reset leaves active
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(0, v); check("R10 reset leaves active", v, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule